// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block is a hardware clock for packet timestamping. It holds time as a seconds count and a nanoseconds count, and the nanoseconds count wraps at one billion. The time does not advance by one step on every core clock. A 32-bit accumulator adds a programmable addend on each clock, and every carry out of that accumulator adds a programmable increment to the nanoseconds. Software tunes the rate in fine steps by changing the addend, and picks the coarse tick size with the increment.

Software uses a simple write port with an address, a data word and a write enable. Through it, software can load an absolute time, step the time forward or backward, activate a newly staged addend, and arm a one-shot alarm against a target time. The alarm drives an interrupt that can be masked. A capture strobe from the frame logic copies the current time into a snapshot pair, and the snapshot holds that value until the next strobe.

Top module: `tod_clock`

## Requirements
- R1: After reset, seconds, nanoseconds, both snapshot words, the pending command bits, the alarm status and the interrupt are all zero. The increment is DEF_INC and the active addend is DEF_ADDEND, which is 0 by default, so the time stands still.
- R2: On every clock the accumulator adds the active addend. Each carry out of bit 31 adds the increment (address 0) to the nanoseconds. With addend 0x8000_0000 this gives exactly 5 increments in any 10 clocks, and with 0x4000_0000 it gives exactly 2 in any 8.
- R3: When a tick or a forward step would take the nanoseconds to one billion or more, the nanoseconds wrap by subtracting one billion and the seconds rise by one. The nanoseconds never hold a value of one billion or more.
- R4: Command bit 0 (address 6) loads the seconds from address 2 and the nanoseconds from bits 29:0 of address 3. The load takes effect one clock after the command write.
- R5: Command bit 1 adds the address 2 and address 3 values to the current time. If bit 31 of the address 3 word is 1, it subtracts them instead. A forward step that overflows the nanoseconds carries into the seconds, and a backward step that goes below zero borrows one second. The magnitude in the nanoseconds word must be below one billion.
- R6: A write to address 1 only stages an addend, which has no effect until command bit 2 activates it. Activation does not change the current seconds or nanoseconds.
- R7: Command bits show on cmdPending (bit 0 load, bit 1 step, bit 2 addend) for the one clock after the write. They clear by themselves once the operation completes. Load wins over step, and step wins over a tick in the same clock.
- R8: A one-clock capture strobe copies the current seconds and nanoseconds into the snapshot outputs. The snapshot stays unchanged while the strobe is low.
- R9: Command bit 3 arms the alarm. While armed, the alarm sets its status one clock after the time becomes equal to or later than the target (seconds at address 4, nanoseconds at address 5), and setting the status disarms it. When the alarm is not armed, the status never sets.
- R10: Writing to address 7 with bit 0 = 1 clears the alarm status, and bit 1 of the same write stores the interrupt enable. The irq output is high only while both the status and the enable are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 3 | Register write address |
| wrData | input | 32 | Register write data |
| captureStb | input | 1 | Timestamp capture strobe |
| secNow | output | SEC_W | Current seconds |
| nsNow | output | 30 | Current nanoseconds |
| snapSec | output | SEC_W | Captured seconds |
| snapNs | output | 30 | Captured nanoseconds |
| cmdPending | output | 3 | Commands not yet applied |
| alarmStatus | output | 1 | Alarm status, cleared by writing 1 |
| irq | output | 1 | Masked alarm interrupt |

## Verification
If the accumulator phase or the addend is wrong, the effect reaches the ports as a wrong count of increments within a short window, so the bench measures exact differences over windows of 8 or 10 clocks. A carry or a borrow applied the wrong way shows up at once, one clock after a command, as a seconds value off by one or a nanoseconds value off by one billion. The table covers each sign and each carry case. Alarm comparator errors show up as a status bit that sets one clock early, one clock late, or not at all. The bench places the time on either side of the target in both seconds and nanoseconds.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int DATA_W  = 32;
  localparam int ACC_W   = 32;
  localparam int NS_ROLL = 1_000_000_000;
  localparam int NS_W    = $clog2(NS_ROLL);
  localparam int ADDR_W  = 3;

  localparam logic [ADDR_W-1:0] ADR_INC    = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_ADDEND = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_USEC   = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_UNS    = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_TSEC   = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_TNS    = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_CMD    = 3'd6;
  localparam logic [ADDR_W-1:0] ADR_IRQ    = 3'd7;

  typedef struct packed {
    logic doReload;
    logic doStep;
    logic doSet;
  } todCmd_t;
endpackage

// File: rtl/tod_ctrl.sv
module tod_ctrl
  import tod_pkg::*;
#(
  parameter int          SEC_W      = 32,
  parameter int          INC_W      = 8,
  parameter int          DEF_INC    = 20,
  parameter logic [31:0] DEF_ADDEND = 32'h0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic                 alarmHit,
  output todCmd_t              cmd,
  output logic [INC_W-1:0]     incVal,
  output logic [ACC_W-1:0]     addStage,
  output logic [SEC_W-1:0]     updSec,
  output logic [NS_W-1:0]      updNsMag,
  output logic                 updNeg,
  output logic [SEC_W-1:0]     tgtSec,
  output logic [NS_W-1:0]      tgtNs,
  output logic                 alarmStatus,
  output logic                 irq
);
  logic trigEn;
  logic irqEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmd         <= '0;
      incVal      <= INC_W'(DEF_INC);
      addStage    <= DEF_ADDEND;
      updSec      <= '0;
      updNsMag    <= '0;
      updNeg      <= 1'b0;
      tgtSec      <= '0;
      tgtNs       <= '0;
      trigEn      <= 1'b0;
      irqEn       <= 1'b0;
      alarmStatus <= 1'b0;
    end else begin
      cmd <= '0;
      if (wrEn) begin
        case (wrAddr)
          ADR_INC:    incVal   <= wrData[INC_W-1:0];
          ADR_ADDEND: addStage <= wrData;
          ADR_USEC:   updSec   <= wrData[SEC_W-1:0];
          ADR_UNS: begin
            updNsMag <= wrData[NS_W-1:0];
            updNeg   <= wrData[DATA_W-1];
          end
          ADR_TSEC:   tgtSec   <= wrData[SEC_W-1:0];
          ADR_TNS:    tgtNs    <= wrData[NS_W-1:0];
          ADR_CMD: begin
            cmd <= '{doReload: wrData[2], doStep: wrData[1], doSet: wrData[0]};
            if (wrData[3]) trigEn <= 1'b1;
          end
          ADR_IRQ: begin
            if (wrData[0]) alarmStatus <= 1'b0;
            irqEn <= wrData[1];
          end
          default: ;
        endcase
      end
      if (trigEn && alarmHit) begin
        alarmStatus <= 1'b1;
        trigEn      <= 1'b0;
      end
    end
  end

  assign irq = alarmStatus & irqEn;

  AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (cmd != '0) && !wrEn |=> cmd == '0); // R7
  AST_ALARM_FIRES: assert property (@(posedge clk) disable iff (!rstN)
    trigEn && alarmHit |=> alarmStatus && !trigEn); // R9
  AST_W1C: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrAddr == ADR_IRQ && wrData[0] && !(trigEn && alarmHit) |=> !alarmStatus); // R10
endmodule

// File: rtl/tod_datapath.sv
module tod_datapath
  import tod_pkg::*;
#(
  parameter int          SEC_W      = 32,
  parameter int          INC_W      = 8,
  parameter logic [31:0] DEF_ADDEND = 32'h0
) (
  input  logic              clk,
  input  logic              rstN,
  input  todCmd_t           cmd,
  input  logic [INC_W-1:0]  incVal,
  input  logic [ACC_W-1:0]  addStage,
  input  logic [SEC_W-1:0]  updSec,
  input  logic [NS_W-1:0]   updNsMag,
  input  logic              updNeg,
  input  logic [SEC_W-1:0]  tgtSec,
  input  logic [NS_W-1:0]   tgtNs,
  input  logic              captureStb,
  output logic [SEC_W-1:0]  secNow,
  output logic [NS_W-1:0]   nsNow,
  output logic [SEC_W-1:0]  snapSec,
  output logic [NS_W-1:0]   snapNs,
  output logic              alarmHit
);
  localparam int NW = NS_W + 2;

  logic [ACC_W-1:0] acc, addAct;
  logic [ACC_W:0]   accSum;
  logic             tick;

  assign accSum = {1'b0, acc} + {1'b0, addAct};
  assign tick   = accSum[ACC_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc    <= '0;
      addAct <= DEF_ADDEND;
    end else begin
      acc <= accSum[ACC_W-1:0];
      if (cmd.doReload) addAct <= addStage;
    end
  end

  logic [NW-1:0]    nsExt, magExt, incExt, rollExt, sumExt, nsNext;
  logic [SEC_W-1:0] secNext;

  assign nsExt   = {2'b00, nsNow};
  assign magExt  = {2'b00, updNsMag};
  assign incExt  = NW'(incVal);
  assign rollExt = NW'(NS_ROLL);

  always_comb begin
    secNext = secNow;
    nsNext  = nsExt;
    sumExt  = '0;
    if (cmd.doSet) begin
      secNext = updSec;
      nsNext  = magExt;
    end else if (cmd.doStep) begin
      if (!updNeg) begin
        sumExt = nsExt + magExt;
        if (sumExt >= rollExt) begin
          nsNext  = sumExt - rollExt;
          secNext = secNow + updSec + SEC_W'(1);
        end else begin
          nsNext  = sumExt;
          secNext = secNow + updSec;
        end
      end else if (nsExt >= magExt) begin
        nsNext  = nsExt - magExt;
        secNext = secNow - updSec;
      end else begin
        nsNext  = nsExt + rollExt - magExt;
        secNext = secNow - updSec - SEC_W'(1);
      end
    end else if (tick) begin
      sumExt = nsExt + incExt;
      if (sumExt >= rollExt) begin
        nsNext  = sumExt - rollExt;
        secNext = secNow + SEC_W'(1);
      end else begin
        nsNext  = sumExt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secNow  <= '0;
      nsNow   <= '0;
      snapSec <= '0;
      snapNs  <= '0;
    end else begin
      secNow <= secNext;
      nsNow  <= nsNext[NS_W-1:0];
      if (captureStb) begin
        snapSec <= secNow;
        snapNs  <= nsNow;
      end
    end
  end

  assign alarmHit = (secNow > tgtSec) || ((secNow == tgtSec) && (nsNow >= tgtNs));

  AST_NS_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    32'(nsNow) < 32'(NS_ROLL)); // R3
  AST_SET_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    cmd.doSet |=> secNow == $past(updSec) && nsNow == $past(updNsMag)); // R4
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !captureStb |=> $stable(snapSec) && $stable(snapNs)); // R8
endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
#(
  parameter int          SEC_W      = 32,
  parameter int          INC_W      = 8,
  parameter int          DEF_INC    = 20,
  parameter logic [31:0] DEF_ADDEND = 32'h0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [31:0]       wrData,
  input  logic              captureStb,
  output logic [SEC_W-1:0]  secNow,
  output logic [29:0]       nsNow,
  output logic [SEC_W-1:0]  snapSec,
  output logic [29:0]       snapNs,
  output logic [2:0]        cmdPending,
  output logic              alarmStatus,
  output logic              irq
);
  todCmd_t          cmd;
  logic [INC_W-1:0] incVal;
  logic [ACC_W-1:0] addStage;
  logic [SEC_W-1:0] updSec, tgtSec;
  logic [NS_W-1:0]  updNsMag, tgtNs;
  logic             updNeg, alarmHit;

  tod_ctrl #(.SEC_W(SEC_W), .INC_W(INC_W), .DEF_INC(DEF_INC), .DEF_ADDEND(DEF_ADDEND)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .alarmHit(alarmHit), .cmd(cmd), .incVal(incVal), .addStage(addStage),
    .updSec(updSec), .updNsMag(updNsMag), .updNeg(updNeg), .tgtSec(tgtSec),
    .tgtNs(tgtNs), .alarmStatus(alarmStatus), .irq(irq)
  );

  tod_datapath #(.SEC_W(SEC_W), .INC_W(INC_W), .DEF_ADDEND(DEF_ADDEND)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .incVal(incVal), .addStage(addStage),
    .updSec(updSec), .updNsMag(updNsMag), .updNeg(updNeg), .tgtSec(tgtSec),
    .tgtNs(tgtNs), .captureStb(captureStb), .secNow(secNow), .nsNow(nsNow),
    .snapSec(snapSec), .snapNs(snapNs), .alarmHit(alarmHit)
  );

  assign cmdPending = {cmd.doReload, cmd.doStep, cmd.doSet};
endmodule

// File: tb/tod_clock_tb_top.sv
module tod_clock_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        captureStb = 1'b0;
  logic [31:0] secNow, snapSec;
  logic [29:0] nsNow, snapNs;
  logic [2:0]  cmdPending;
  logic        alarmStatus, irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tod_clock dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .captureStb(captureStb), .secNow(secNow), .nsNow(nsNow), .snapSec(snapSec),
    .snapNs(snapNs), .cmdPending(cmdPending), .alarmStatus(alarmStatus), .irq(irq)
  );

  // start sec, start ns, step sec, step ns word, expected sec, expected ns
  localparam logic [31:0] VEC [6][6] = '{
    '{32'd10, 32'd100,         32'd2, 32'd50,          32'd12, 32'd150},
    '{32'd10, 32'd999_999_000, 32'd1, 32'd2_000,       32'd12, 32'd1_000},
    '{32'd10, 32'd500,         32'd3, 32'h8000_00C8,   32'd7,  32'd300},
    '{32'd10, 32'd100,         32'd3, 32'h8000_00C8,   32'd6,  32'd999_999_900},
    '{32'd0,  32'd999_999_999, 32'd0, 32'd1,           32'd1,  32'd0},
    '{32'd5,  32'd0,           32'd0, 32'h8000_0000,   32'd5,  32'd0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic command(input logic [31:0] bits);
    regWrite(3'd6, bits);
    @(negedge clk);
  endtask

  task automatic setTime(input logic [31:0] s, input logic [31:0] n);
    regWrite(3'd2, s);
    regWrite(3'd3, n);
    command(32'd1);
  endtask

  task automatic stepTime(input logic [31:0] s, input logic [31:0] n);
    regWrite(3'd2, s);
    regWrite(3'd3, n);
    command(32'd2);
  endtask

  task automatic pulseCapture();
    @(negedge clk);
    captureStb = 1'b1;
    @(negedge clk);
    captureStb = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    logic [29:0] base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sec", 64'(secNow), 0);
    chk("R1 ns", 64'(nsNow), 0);
    chk("R1 snap", 64'({snapSec, 2'b00, snapNs}), 0);
    chk("R1 pending", 64'(cmdPending), 0);
    chk("R1 alarm", 64'({alarmStatus, irq}), 0);
    repeat (5) @(negedge clk);
    chk("R1 frozen", 64'(nsNow), 0);

    // R7 pending for one clock
    regWrite(3'd6, 32'd1);
    chk("R7 pending set", 64'(cmdPending), 64'd1);
    @(negedge clk);
    chk("R7 pending cleared", 64'(cmdPending), 0);
    regWrite(3'd6, 32'd6);
    chk("R7 pending step+reload", 64'(cmdPending), 64'd6);
    @(negedge clk);
    chk("R7 pending cleared 2", 64'(cmdPending), 0);

    // R4 / R5 table walk
    for (int i = 0; i < 6; i++) begin
      setTime(VEC[i][0], VEC[i][1]);
      chk("R4 set sec", 64'(secNow), 64'(VEC[i][0]));
      chk("R4 set ns", 64'(nsNow), 64'(VEC[i][1]));
      stepTime(VEC[i][2], VEC[i][3]);
      chk("R5 step sec", 64'(secNow), 64'(VEC[i][4]));
      chk("R5 step ns", 64'(nsNow), 64'(VEC[i][5]));
    end

    // R6 staged addend has no effect until reload; reload keeps time
    setTime(32'd7, 32'd1000);
    regWrite(3'd1, 32'h8000_0000);
    repeat (6) @(negedge clk);
    chk("R6 staged only", 64'(nsNow), 64'd1000);
    command(32'd4);
    chk("R6 reload keeps ns", 64'(nsNow), 64'd1000);
    chk("R6 reload keeps sec", 64'(secNow), 64'd7);

    // R2 rate: 5 carries per 10 clocks
    base = nsNow;
    repeat (10) @(negedge clk);
    chk("R2 half rate inc20", 64'(nsNow - base), 64'd100);
    regWrite(3'd0, 32'd50);
    base = nsNow;
    repeat (10) @(negedge clk);
    chk("R2 half rate inc50", 64'(nsNow - base), 64'd250);
    regWrite(3'd1, 32'h4000_0000);
    command(32'd4);
    base = nsNow;
    repeat (8) @(negedge clk);
    chk("R2 quarter rate", 64'(nsNow - base), 64'd100);

    // R3 rollover by tick
    regWrite(3'd0, 32'd20);
    regWrite(3'd1, 32'h8000_0000);
    command(32'd4);
    setTime(32'd5, 32'd999_999_990);
    repeat (4) @(negedge clk);
    chk("R3 roll sec", 64'(secNow), 64'd6);
    chk("R3 roll ns", 64'(nsNow), 64'd30);
    regWrite(3'd1, 32'h0);
    command(32'd4);

    // R8 capture
    setTime(32'd20, 32'd111);
    pulseCapture();
    chk("R8 snap sec", 64'(snapSec), 64'd20);
    chk("R8 snap ns", 64'(snapNs), 64'd111);
    setTime(32'd21, 32'd222);
    chk("R8 snap held", 64'({snapSec, 2'b00, snapNs}), {32'd20, 32'd111});
    pulseCapture();
    chk("R8 snap new", 64'({snapSec, 2'b00, snapNs}), {32'd21, 32'd222});

    // R9 / R10 alarm
    regWrite(3'd7, 32'd2);
    setTime(32'd30, 32'd500);
    regWrite(3'd4, 32'd30);
    regWrite(3'd5, 32'd600);
    regWrite(3'd6, 32'd8);
    repeat (2) @(negedge clk);
    chk("R9 before target", 64'(alarmStatus), 0);
    setTime(32'd30, 32'd600);
    @(negedge clk);
    chk("R9 equal fires", 64'(alarmStatus), 1);
    chk("R10 irq enabled", 64'(irq), 1);
    regWrite(3'd7, 32'd3);
    chk("R10 w1c", 64'({alarmStatus, irq}), 0);
    repeat (2) @(negedge clk);
    chk("R9 one shot", 64'(alarmStatus), 0);
    setTime(32'd40, 32'd0);
    repeat (2) @(negedge clk);
    chk("R9 not armed", 64'(alarmStatus), 0);
    regWrite(3'd6, 32'd8);
    @(negedge clk);
    chk("R9 already past", 64'(alarmStatus), 1);
    regWrite(3'd7, 32'd0);
    chk("R10 masked status", 64'(alarmStatus), 1);
    chk("R10 masked irq", 64'(irq), 0);
    regWrite(3'd7, 32'd1);
    chk("R10 clear", 64'(alarmStatus), 0);
    regWrite(3'd4, 32'd31);
    regWrite(3'd5, 32'd0);
    setTime(32'd30, 32'd999_999_999);
    regWrite(3'd6, 32'd8);
    repeat (2) @(negedge clk);
    chk("R9 seconds dominate", 64'(alarmStatus), 0);
    setTime(32'd31, 32'd0);
    @(negedge clk);
    chk("R9 seconds reached", 64'(alarmStatus), 1);

    finish();
  end
endmodule